// File: doc/BRIEF.md
# Packet-Tagged Receive Byte Queue

This block holds received bytes between a serial frame receiver and a processor read port. Every byte is stored with a two-bit position tag. The tag says whether the byte opens a packet, sits inside one, or closes one. A closing byte is tagged as either a good or a bad frame end. The byte and tag at the head of the queue are always shown on the read side, so software can look at the tag of the next byte before it pops it. This lets software find packet boundaries without reading any extra status.

The queue holds nineteen entries. Occupancy flags are registered. An `almost_full` level is asserted once fifteen entries are held. An interrupt request combines that level with a sticky overflow flag. A write into a full queue is lost and sets the overflow flag. A status read clears that flag. A synchronous `flush` input empties the queue and clears every flag, and the asynchronous reset does the same.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: The queue accepts exactly DEPTH (default 19) bytes. `full` is 1 once DEPTH entries are held and `empty` is 0 whenever `full` is 1.
- R2: Bytes and their tags leave in the order they were written. The tag codes are 2'b00 body byte, 2'b01 first byte, 2'b10 last byte of a good frame and 2'b11 last byte of a bad or aborted frame. Both data and tag are returned unchanged.
- R3: While the queue is not empty, `head_data` and `head_tag` show the entry that the next pop returns. They do not change until a pop or a flush occurs.
- R4: `almost_full` is 1 exactly when at least THRESH (default 15) entries are held. With 14 entries it is 0, and with 15 entries it is 1.
- R5: A push while the queue is full and no pop is made in the same cycle is dropped. The stored contents are unchanged, and `overflow` is set. `overflow` stays set until a cycle with `stat_rd` high and no new overflow event.
- R6: `empty`, `full` and `almost_full` are registered. They change at the clock edge that takes the push or pop, never before it.
- R7: Reset, and a cycle with `flush` high, leave the queue empty with `empty`=1 and `full`, `almost_full`, `overflow` and `irq` at 0.
- R8: A push and a pop in the same cycle on a non-empty queue leave the occupancy unchanged. This includes a full queue, where both are taken.
- R9: A pop on an empty queue is ignored.
- R10: `irq` is 1 whenever `almost_full` or `overflow` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of queue and flags |
| push | input | 1 | Write request from the receiver |
| push_data | input | DATA_W | Byte to store |
| push_tag | input | 2 | Position tag of the byte |
| pop | input | 1 | Read request; removes the head entry |
| stat_rd | input | 1 | Status read strobe; clears overflow |
| head_data | output | DATA_W | Byte at the head of the queue |
| head_tag | output | 2 | Tag of the byte at the head |
| empty | output | 1 | No entries held |
| full | output | 1 | DEPTH entries held |
| almost_full | output | 1 | At least THRESH entries held |
| overflow | output | 1 | Sticky: a push was lost |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default values DATA_W=8, DEPTH=19 and THRESH=15. With these values it reaches the exact 14/15 threshold edge, a completely full queue, and the dropped twentieth write. The odd depth also makes both pointers wrap at a boundary that is not a power of two. After the full-queue push/pop case, the bench drains the whole queue. This makes the read pointer pass through the wrap point while the expected byte order is checked.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    TAG_BODY    = 2'b00,
    TAG_FIRST   = 2'b01,
    TAG_END_OK  = 2'b10,
    TAG_END_BAD = 2'b11
  } rxq_tag_e;

  localparam int TAG_W = 2;
endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
  parameter int DEPTH = 19,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_n;
  logic          ptr_en;

  always_comb begin
    ptr_en = clr | adv;
    if (clr)               ptr_n = '0;
    else if (ptr_q == LAST) ptr_n = '0;
    else                   ptr_n = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 19,
  parameter int WIDTH = 10,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH  = 19,
  parameter int THRESH = 15,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  logic pop,
  input  logic stat_rd,
  output logic push_ok,
  output logic pop_ok,
  output logic empty,
  output logic full,
  output logic almost_full,
  output logic overflow
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_THR  = CW'(THRESH);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          empty_q, full_q, af_q, ovf_q;
  logic          empty_n, full_n, af_n, ovf_n;
  logic          ovf_evt;

  always_comb begin
    pop_ok  = pop & ~empty_q & ~flush;
    push_ok = push & (~full_q | pop) & ~flush;
    ovf_evt = push & full_q & ~pop & ~flush;

    cnt_en = flush | (push_ok ^ pop_ok);
    if (flush)        cnt_n = '0;
    else if (push_ok && !pop_ok) cnt_n = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_n = cnt_q - CW'(1);
    else              cnt_n = cnt_q;

    empty_n = (cnt_n == '0);
    full_n  = (cnt_n == CNT_FULL);
    af_n    = (cnt_n >= CNT_THR);

    if (flush)        ovf_n = 1'b0;
    else if (ovf_evt) ovf_n = 1'b1;
    else if (stat_rd) ovf_n = 1'b0;
    else              ovf_n = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      af_q    <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_n;
      empty_q <= empty_n;
      full_q  <= full_n;
      af_q    <= af_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_n;
  end

  assign empty       = empty_q;
  assign full        = full_q;
  assign almost_full = af_q;
  assign overflow    = ovf_q;
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 19,
  parameter int THRESH = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [1:0]        push_tag,
  input  logic              pop,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] head_data,
  output logic [1:0]        head_tag,
  output logic              empty,
  output logic              full,
  output logic              almost_full,
  output logic              overflow,
  output logic              irq
);
  import rxq_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DATA_W + TAG_W;

  logic          push_ok, pop_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] wr_entry, rd_entry;

  rxq_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .stat_rd(stat_rd), .push_ok(push_ok), .pop_ok(pop_ok),
    .empty(empty), .full(full), .almost_full(almost_full),
    .overflow(overflow)
  );

  rxq_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_n), .clr(flush), .adv(push_ok), .ptr(wr_ptr)
  );

  rxq_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_n), .clr(flush), .adv(pop_ok), .ptr(rd_ptr)
  );

  assign wr_entry = {push_tag, push_data};

  rxq_store #(.DEPTH(DEPTH), .WIDTH(EW)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_entry),
    .raddr(rd_ptr), .rdata(rd_entry)
  );

  assign head_tag  = rd_entry[EW-1 -: TAG_W];
  assign head_data = rd_entry[DATA_W-1:0];
  assign irq       = almost_full | overflow;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              push,
  input logic              pop,
  input logic              stat_rd,
  input logic [DATA_W-1:0] head_data,
  input logic [1:0]        head_tag,
  input logic              empty,
  input logic              full,
  input logic              almost_full,
  input logic              overflow,
  input logic              irq
);
  a_r1_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);

  a_r4_full_implies_level: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almost_full);

  a_r3_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop && !flush) |=> ($stable(head_data) && $stable(head_tag)));

  a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (overflow && full));

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !stat_rd && !flush) |=> overflow);

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !full && !almost_full && !overflow && !irq));

  a_r8_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && push && pop && !flush) |=>
      ($stable(empty) && $stable(full) && $stable(almost_full)));

  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);

  a_r10_irq_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (almost_full || overflow) |-> irq);
endmodule

bind rxq_tagged_fifo rxq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
  .stat_rd(stat_rd), .head_data(head_data), .head_tag(head_tag),
  .empty(empty), .full(full), .almost_full(almost_full),
  .overflow(overflow), .irq(irq)
);

// File: tb/tb_rxq_tagged_fifo.sv
`timescale 1ns/1ps
module tb_rxq_tagged_fifo;
  localparam int DEPTH = 19;

  logic       clk = 1'b0;
  logic       rst_n, flush, push, pop, stat_rd;
  logic [7:0] push_data, head_data;
  logic [1:0] push_tag, head_tag;
  logic       empty, full, almost_full, overflow, irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [9:0] q [$];

  always #2.5 clk = ~clk;

  rxq_tagged_fifo dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
    .push_data(push_data), .push_tag(push_tag), .pop(pop),
    .stat_rd(stat_rd), .head_data(head_data), .head_tag(head_tag),
    .empty(empty), .full(full), .almost_full(almost_full),
    .overflow(overflow), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ps, input logic [7:0] d, input logic [1:0] t,
                      input logic pp, input logic sr, input logic fl);
    @(negedge clk);
    push = ps; push_data = d; push_tag = t; pop = pp; stat_rd = sr; flush = fl;
    @(posedge clk);
    #1;
    push = 1'b0; pop = 1'b0; stat_rd = 1'b0; flush = 1'b0;
  endtask

  task automatic put(input logic [7:0] d, input logic [1:0] t);
    if (q.size() < DEPTH) q.push_back({t, d});
    step(1'b1, d, t, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic take(input string req);
    logic [9:0] e;
    e = q.pop_front();
    chk(req, "head_data", head_data, e[7:0]);
    chk(req, "head_tag", head_tag, e[9:8]);
    step(1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) take(req);
    chk(req, "empty after drain", empty, 1);
  endtask

  task automatic t_reset;
    chk("R7", "empty at reset", empty, 1);
    chk("R7", "full at reset", full, 0);
    chk("R7", "almost_full at reset", almost_full, 0);
    chk("R7", "overflow at reset", overflow, 0);
    chk("R7", "irq at reset", irq, 0);
  endtask

  task automatic t_registered_flags;
    @(negedge clk);
    push = 1'b1; push_data = 8'hA5; push_tag = 2'b01;
    #1;
    chk("R6", "empty before edge", empty, 1);
    @(posedge clk);
    #1;
    push = 1'b0;
    q.push_back({2'b01, 8'hA5});
    chk("R6", "empty after edge", empty, 0);
    drain("R6");
  endtask

  task automatic t_order;
    put(8'h11, 2'b01);
    put(8'h22, 2'b00);
    put(8'h33, 2'b10);
    put(8'h44, 2'b01);
    put(8'h55, 2'b11);
    chk("R3", "head tag before pop", head_tag, 2'b01);
    step(1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0);
    chk("R3", "head data held", head_data, 8'h11);
    drain("R2");
  endtask

  task automatic t_threshold_full;
    for (int i = 0; i < 14; i++) put(8'(8'h80 + i), 2'(i % 4));
    chk("R4", "almost_full at 14", almost_full, 0);
    chk("R10", "irq at 14", irq, 0);
    put(8'h8E, 2'b10);
    chk("R4", "almost_full at 15", almost_full, 1);
    chk("R10", "irq at 15", irq, 1);
    for (int i = 15; i < DEPTH; i++) put(8'(8'h80 + i), 2'b00);
    chk("R1", "full at depth", full, 1);
    chk("R1", "empty at depth", empty, 0);
    chk("R5", "overflow before drop", overflow, 0);
    put(8'hEE, 2'b11);
    chk("R5", "overflow set", overflow, 1);
    chk("R5", "full still", full, 1);
    step(1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0);
    chk("R5", "overflow sticky", overflow, 1);
    step(1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0);
    chk("R5", "overflow cleared", overflow, 0);
    // R8: push and pop together on a full queue
    begin
      logic [9:0] e;
      e = q.pop_front();
      chk("R8", "head before push+pop", head_data, e[7:0]);
      q.push_back({2'b10, 8'h5A});
      step(1'b1, 8'h5A, 2'b10, 1'b1, 1'b0, 1'b0);
    end
    chk("R8", "full kept", full, 1);
    chk("R8", "overflow not set", overflow, 0);
    drain("R2");
  endtask

  task automatic t_pushpop_partial;
    put(8'h01, 2'b01);
    put(8'h02, 2'b00);
    put(8'h03, 2'b00);
    begin
      logic [9:0] e;
      e = q.pop_front();
      chk("R8", "head before push+pop", head_data, e[7:0]);
      q.push_back({2'b10, 8'h04});
      step(1'b1, 8'h04, 2'b10, 1'b1, 1'b0, 1'b0);
    end
    chk("R8", "size held, take 1", empty, 0);
    take("R8");
    take("R8");
    chk("R8", "not empty with one left", empty, 0);
    take("R8");
    chk("R8", "empty after three pops", empty, 1);
  endtask

  task automatic t_empty_pop;
    step(1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b0);
    chk("R9", "empty after pop on empty", empty, 1);
    put(8'h77, 2'b01);
    chk("R9", "head after ignored pop", head_data, 8'h77);
    drain("R9");
  endtask

  task automatic t_flush;
    for (int i = 0; i < DEPTH + 1; i++) put(8'(i), 2'b00);
    chk("R7", "overflow before flush", overflow, 1);
    step(1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b1);
    q.delete();
    chk("R7", "empty after flush", empty, 1);
    chk("R7", "full after flush", full, 0);
    chk("R7", "almost_full after flush", almost_full, 0);
    chk("R7", "overflow after flush", overflow, 0);
    chk("R7", "irq after flush", irq, 0);
    put(8'h3C, 2'b11);
    chk("R7", "head after flush", head_data, 8'h3C);
    drain("R7");
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; push = 1'b0; pop = 1'b0; stat_rd = 1'b0;
    push_data = '0; push_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_registered_flags();
    t_order();
    t_threshold_full();
    t_pushpop_partial();
    t_empty_pop();
    t_flush();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule